// File: doc/BRIEF.md
# Host Indirect Memory Access Port

This block is a byte-wide register file that sits between a host processor and an adapter's local memory and control lines. The host never addresses adapter memory directly. It loads a 24-bit pointer one byte at a time, then moves data through one of two data registers. One leaves the pointer where it is. The other advances the pointer by one after every access. That lets the host sweep a buffer with a single repeated register address. Memory accesses are issued on a synchronous memory port, and only while the pointer lies below the implemented memory size.

Each adapter channel (one or four, chosen by parameter) has its own control register. The control register holds the channel's processor in reset or halt. It also carries two doorbells. One is an adapter-to-host pending flag that the host clears by writing a one, and that can be routed to one of seven host interrupt lines. The other is a host-to-adapter request that stays high until the adapter acknowledges it. A separate adapter-level register picks which channel the control register and the memory port refer to. The same register shows the pending flags of all channels at once, and the host cannot change them there.

Host reads return data on `host_rdata` in the cycle after `host_rd`. Between reads `host_rdata` is 0x00.

Top module: `hima_port`

## Requirements
- R1: Offset 0 reads 0xA4 when the block has four channels, and 0xA1 when it has one. Every host read returns its byte on `host_rdata` exactly one cycle after `host_rd`. In any cycle that does not follow a read, `host_rdata` is 0x00.
- R2: Offsets 2, 3 and 4 write and read pointer bits 7:0, 15:8 and 23:16. The pointer is 0 after reset and always appears on `mem_addr`.
- R3: A read or write at offset 5 does the memory access at the current pointer and leaves the pointer unchanged.
- R4: A read or write at offset 6 does the memory access at the current pointer and then adds one to the pointer. The pointer wraps from 0xFFFFFF to 0x000000.
- R5: While the pointer is at or above 0x40000, a data access raises neither `mem_we` nor `mem_re`, and a data read returns 0x00. At 0x3FFFF the access goes through.
- R6: Offset 1 accesses the control register of the selected channel. Bit 7 drives `adp_reset` of that channel and bit 4 drives `adp_halt`. Both are read/write. After reset, bit 7 is 1 and bit 4 is 0.
- R7: Control bit 6 reads 1 once the channel's `adp_irq_set` has pulsed. Writing 1 to bit 6 clears it, and writing 0 to bit 6 leaves it unchanged. If a set and a clear happen in the same cycle, the set wins.
- R8: Writing 1 to control bit 5 raises `adp_doorbell` of that channel, and bit 5 reads 1. A pulse on `adp_ack` drops the doorbell, and bit 5 then reads 0.
- R9: Control bit 3 enables routing of a pending channel to `host_irq`. Bits 2:0 pick the line: code 0 drives no line, and codes 1 to 7 drive lines 3, 5, 7, 10, 11, 12 and 15.
- R10: Offset 8 bits 1:0 select the channel for offset 1 and for `mem_chan`. Bits 7:4 read the pending flags of channels 3 to 0, with channel c at bit 4+c. Writes cannot change bits 7:2, and clearing a flag from offset 1 affects only the selected channel.
- R11: Reads of offset 7 and of offsets 9 to 15 return 0x00. Writes to those offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_addr | input | HOST_AW | Host register offset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, one cycle after the read |
| mem_addr | output | ADDR_W | Memory address (current pointer) |
| mem_chan | output | 2 | Selected channel for the memory access |
| mem_we | output | 1 | Memory write enable |
| mem_re | output | 1 | Memory read enable, data expected next cycle |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data |
| adp_irq_set | input | NUM_CHAN | Adapter raises its pending flag to the host |
| adp_ack | input | NUM_CHAN | Adapter acknowledges the host doorbell |
| adp_reset | output | NUM_CHAN | Channel processor held in reset |
| adp_halt | output | NUM_CHAN | Channel processor held in halt |
| adp_doorbell | output | NUM_CHAN | Host-to-adapter request per channel |
| host_irq | output | 16 | Host interrupt lines |

## Verification
The pointer is tested in three ways. It is loaded byte by byte and read back. It is stepped through a run of auto-increment writes and then re-read in both hold and increment modes. This separates the two data registers by where the pointer ends up. Accesses are placed at 0x3FFFF, at 0x40000 and at 0xFFFFFF, which exposes an off-by-one in the memory limit and a pointer that fails to wrap. The doorbells are driven with a set alone, a write of 0, a write-one clear, and a set colliding with a clear. Routing codes 0, 2 and 7 are used on a pending channel, and the channel-select register is exercised so that one channel's controls are shown not to leak into another's.

// File: rtl/hima_pkg.sv
package hima_pkg;

   localparam int OFS_ID      = 0;
   localparam int OFS_CTRL    = 1;
   localparam int OFS_PTR0    = 2;
   localparam int OFS_DATA    = 5;
   localparam int OFS_DATA_INC = 6;
   localparam int OFS_ADP     = 8;

   // Bit order follows the host-visible control register layout.
   typedef struct packed {
      logic       rst;
      logic       pend;
      logic       bell;
      logic       halt;
      logic       pend_en;
      logic [2:0] line_code;
   } chan_ctrl_t;

   function automatic logic [3:0] irq_line(input logic [2:0] code);
      case (code)
         3'd1:    irq_line = 4'd3;
         3'd2:    irq_line = 4'd5;
         3'd3:    irq_line = 4'd7;
         3'd4:    irq_line = 4'd10;
         3'd5:    irq_line = 4'd11;
         3'd6:    irq_line = 4'd12;
         default: irq_line = 4'd15;
      endcase
   endfunction

endpackage

// File: rtl/hima_ptr.sv
module hima_ptr #(
   parameter int ADDR_W = 24
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W/8-1:0] ld_en,
   input  logic [7:0]          ld_data,
   input  logic                inc,
   output logic [ADDR_W-1:0]   ptr
);
   localparam int NBYTES = ADDR_W / 8;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr <= '0;
      end else if (inc) begin
         ptr <= ptr + 1'b1;
      end else begin
         for (int b = 0; b < NBYTES; b++) begin
            if (ld_en[b]) ptr[8*b +: 8] <= ld_data;
         end
      end
   end
endmodule

// File: rtl/hima_chan_ctrl.sv
module hima_chan_ctrl
   import hima_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [7:0] wdata,
   input  logic       irq_set,
   input  logic       ack,
   output chan_ctrl_t st
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st           <= '0;
         st.rst       <= 1'b1;
      end else begin
         if (wr_en) begin
            st.rst       <= wdata[7];
            st.halt      <= wdata[4];
            st.pend_en   <= wdata[3];
            st.line_code <= wdata[2:0];
         end
         if (irq_set)                 st.pend <= 1'b1;
         else if (wr_en && wdata[6])  st.pend <= 1'b0;
         if (wr_en && wdata[5])       st.bell <= 1'b1;
         else if (ack)                st.bell <= 1'b0;
      end
   end
endmodule

// File: rtl/hima_irq_route.sv
module hima_irq_route
   import hima_pkg::*;
#(
   parameter int NUM_CHAN = 4,
   parameter int LINES    = 16
) (
   input  chan_ctrl_t [NUM_CHAN-1:0] ch,
   output logic [LINES-1:0]          irq
);
   always_comb begin
      irq = '0;
      for (int c = 0; c < NUM_CHAN; c++) begin
         if (ch[c].pend && ch[c].pend_en && (ch[c].line_code != 3'd0))
            irq[irq_line(ch[c].line_code)] = 1'b1;
      end
   end
endmodule

// File: rtl/hima_port.sv
module hima_port
   import hima_pkg::*;
#(
   parameter int              NUM_CHAN  = 4,
   parameter int              ADDR_W    = 24,
   parameter logic [ADDR_W-1:0] MEM_LIMIT = 24'h040000,
   parameter int              HOST_AW   = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [HOST_AW-1:0]  host_addr,
   input  logic                host_wr,
   input  logic                host_rd,
   input  logic [7:0]          host_wdata,
   output logic [7:0]          host_rdata,
   output logic [ADDR_W-1:0]   mem_addr,
   output logic [1:0]          mem_chan,
   output logic                mem_we,
   output logic                mem_re,
   output logic [7:0]          mem_wdata,
   input  logic [7:0]          mem_rdata,
   input  logic [NUM_CHAN-1:0] adp_irq_set,
   input  logic [NUM_CHAN-1:0] adp_ack,
   output logic [NUM_CHAN-1:0] adp_reset,
   output logic [NUM_CHAN-1:0] adp_halt,
   output logic [NUM_CHAN-1:0] adp_doorbell,
   output logic [15:0]         host_irq
);
   localparam int        PTR_BYTES = ADDR_W / 8;
   localparam int        CSEL_W    = 2;
   localparam logic [7:0] ID_VAL   = (NUM_CHAN == 4) ? 8'hA4 : 8'hA1;

   initial begin
      assert (NUM_CHAN == 1 || NUM_CHAN == 4)
         else $error("hima_port: NUM_CHAN must be 1 or 4");
      assert (ADDR_W % 8 == 0 && PTR_BYTES >= 1 && PTR_BYTES <= 3)
         else $error("hima_port: ADDR_W must be 8, 16 or 24");
      assert (HOST_AW >= 4)
         else $error("hima_port: HOST_AW must be at least 4");
   end

   logic                  acc;
   logic                  hit_hold, hit_inc, in_range;
   logic [ADDR_W-1:0]     ptr;
   logic [PTR_BYTES-1:0]  ld_en;
   logic [CSEL_W-1:0]     csel;
   chan_ctrl_t [NUM_CHAN-1:0] ch;
   chan_ctrl_t            sel_ctrl;
   logic [3:0]            pend_vec;
   logic [7:0]            reg_rd, rd_q;
   logic                  mem_sel_q;

   assign acc      = host_wr | host_rd;
   assign hit_hold = (host_addr == HOST_AW'(OFS_DATA));
   assign hit_inc  = (host_addr == HOST_AW'(OFS_DATA_INC));
   assign in_range = (ptr < MEM_LIMIT);

   // Pointer byte loads, one strobe per implemented byte.
   for (genvar b = 0; b < PTR_BYTES; b++) begin : g_ld
      assign ld_en[b] = host_wr && (host_addr == HOST_AW'(OFS_PTR0 + b));
   end

   hima_ptr #(.ADDR_W(ADDR_W)) u_ptr (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld_en   (ld_en),
      .ld_data (host_wdata),
      .inc     (acc && hit_inc),
      .ptr     (ptr)
   );

   assign mem_addr  = ptr;
   assign mem_chan  = csel;
   assign mem_wdata = host_wdata;
   assign mem_we    = host_wr && (hit_hold || hit_inc) && in_range;
   assign mem_re    = host_rd && (hit_hold || hit_inc) && in_range;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         csel <= '0;
      else if (host_wr && host_addr == HOST_AW'(OFS_ADP))
         csel <= host_wdata[CSEL_W-1:0];
   end

   for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
      hima_chan_ctrl u_ctrl (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (host_wr && host_addr == HOST_AW'(OFS_CTRL) && csel == CSEL_W'(c)),
         .wdata   (host_wdata),
         .irq_set (adp_irq_set[c]),
         .ack     (adp_ack[c]),
         .st      (ch[c])
      );
      assign adp_reset[c]    = ch[c].rst;
      assign adp_halt[c]     = ch[c].halt;
      assign adp_doorbell[c] = ch[c].bell;
   end

   hima_irq_route #(.NUM_CHAN(NUM_CHAN), .LINES(16)) u_route (
      .ch  (ch),
      .irq (host_irq)
   );

   always_comb begin
      sel_ctrl = '0;
      pend_vec = '0;
      for (int c = 0; c < NUM_CHAN; c++) begin
         pend_vec[c] = ch[c].pend;
         if (csel == CSEL_W'(c)) sel_ctrl = ch[c];
      end
   end

   always_comb begin
      reg_rd = 8'h00;
      if (host_addr == HOST_AW'(OFS_ID))   reg_rd = ID_VAL;
      if (host_addr == HOST_AW'(OFS_CTRL)) reg_rd = sel_ctrl;
      if (host_addr == HOST_AW'(OFS_ADP))  reg_rd = {pend_vec, 2'b00, csel};
      for (int b = 0; b < PTR_BYTES; b++) begin
         if (host_addr == HOST_AW'(OFS_PTR0 + b)) reg_rd = ptr[8*b +: 8];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q      <= 8'h00;
         mem_sel_q <= 1'b0;
      end else begin
         rd_q      <= host_rd ? reg_rd : 8'h00;
         mem_sel_q <= mem_re;
      end
   end

   assign host_rdata = mem_sel_q ? mem_rdata : rd_q;
endmodule

// File: rtl/hima_port_chk.sv
module hima_port_chk #(
   parameter int                NUM_CHAN  = 4,
   parameter int                ADDR_W    = 24,
   parameter logic [ADDR_W-1:0] MEM_LIMIT = 24'h040000,
   parameter int                HOST_AW   = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic [HOST_AW-1:0] host_addr,
   input logic               host_wr,
   input logic               host_rd,
   input logic               wdata_b5,
   input logic               wdata_b7,
   input logic [7:0]         host_rdata,
   input logic [ADDR_W-1:0]  mem_addr,
   input logic               mem_we,
   input logic               mem_re,
   input logic               bell0,
   input logic               reset0,
   input logic [1:0]         csel,
   input logic [3:0]         pend_vec,
   input logic [15:0]        host_irq
);
   // R1: no read in the previous cycle means an idle read bus
   p_rdata_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(host_rd) |-> host_rdata == 8'h00);

   // R3: hold-mode data access keeps the pointer
   p_ptr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((host_wr || host_rd) && host_addr == HOST_AW'(5)) |=> $stable(mem_addr));

   // R4: increment-mode data access advances the pointer by one
   p_ptr_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((host_wr || host_rd) && host_addr == HOST_AW'(6)) |=>
         mem_addr == ADDR_W'($past(mem_addr) + 1'b1));

   // R5: no memory strobe at or above the limit
   p_no_mem_above_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we || mem_re) |-> mem_addr < MEM_LIMIT);

   // R6: channel 0 leaves reset only through a host write
   p_reset_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(reset0) |-> $past(host_wr && host_addr == HOST_AW'(1) && !wdata_b7 && csel == 2'd0));

   // R8: channel 0 doorbell rises only through a host write
   p_bell_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bell0) |-> $past(host_wr && host_addr == HOST_AW'(1) && wdata_b5 && csel == 2'd0));

   // R9: an interrupt line needs a pending channel
   p_irq_needs_pend_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (host_irq != 16'h0) |-> (pend_vec != 4'h0));
endmodule

bind hima_port hima_port_chk #(
   .NUM_CHAN(NUM_CHAN), .ADDR_W(ADDR_W), .MEM_LIMIT(MEM_LIMIT), .HOST_AW(HOST_AW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
   .host_rd(host_rd), .wdata_b5(host_wdata[5]), .wdata_b7(host_wdata[7]),
   .host_rdata(host_rdata), .mem_addr(mem_addr), .mem_we(mem_we),
   .mem_re(mem_re), .bell0(adp_doorbell[0]), .reset0(adp_reset[0]),
   .csel(csel), .pend_vec(pend_vec), .host_irq(host_irq)
);

// File: tb/tb_hima_port.sv
module tb_hima_port;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  host_addr = '0;
   logic        host_wr = 1'b0, host_rd = 1'b0;
   logic [7:0]  host_wdata = '0;
   logic [7:0]  host_rdata;
   logic [23:0] mem_addr;
   logic [1:0]  mem_chan;
   logic        mem_we, mem_re;
   logic [7:0]  mem_wdata;
   logic [7:0]  mem_rdata = '0;
   logic [3:0]  adp_irq_set = '0, adp_ack = '0;
   logic [3:0]  adp_reset, adp_halt, adp_doorbell;
   logic [15:0] host_irq;

   int total = 0, bad = 0;
   logic [7:0]  mem_model [4096];
   logic [7:0]  exp_q [$];
   string       tag_q [$];
   logic        rd_prev = 1'b0;
   logic        done = 1'b0;

   always #2 clk = ~clk;

   hima_port dut (.*);

   // Memory environment: synchronous, one cycle read latency.
   always @(posedge clk) begin
      if (mem_we) mem_model[mem_addr[11:0]] <= mem_wdata;
      if (mem_re) mem_rdata <= mem_model[mem_addr[11:0]];
   end

   // Monitor: compares each returned read against the scoreboard queue.
   always @(posedge clk) rd_prev <= host_rd;
   always @(negedge clk) begin
      if (rd_prev) begin
         total++;
         if (exp_q.size() == 0) begin
            bad++;
            $display("FAIL %s: read with empty scoreboard got=%02h exp=none", "R1", host_rdata);
         end else begin
            automatic logic [7:0] e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            if (host_rdata !== e) begin
               bad++;
               $display("FAIL %s: host_rdata got=%02h exp=%02h", t, host_rdata, e);
            end
         end
      end
   end

   task automatic chk(input string t, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got=%0h exp=%0h", t, got, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      host_addr = a; host_wdata = d; host_wr = 1'b1;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, input logic [7:0] e, input string t);
      host_addr = a; host_rd = 1'b1;
      exp_q.push_back(e); tag_q.push_back(t);
      @(negedge clk);
      host_rd = 1'b0;
   endtask

   task automatic set_ptr(input logic [23:0] p);
      wr(4'd2, p[7:0]); wr(4'd3, p[15:8]); wr(4'd4, p[23:16]);
   endtask

   task automatic pulse_irq(input int c);
      adp_irq_set[c] = 1'b1; @(negedge clk); adp_irq_set[c] = 1'b0;
   endtask

   initial begin
      for (int i = 0; i < 4096; i++) mem_model[i] = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // Reset state
      chk("R6 reset", adp_reset, 4'hF);
      chk("R6 halt", adp_halt, 4'h0);
      chk("R8 bell", adp_doorbell, 4'h0);
      chk("R9 irq", host_irq, 16'h0);
      chk("R2 ptr", mem_addr, 24'h0);
      chk("R1 idle", host_rdata, 8'h00);

      rd(4'd0, 8'hA4, "R1 id");

      // R11 reserved / unmapped offsets
      rd(4'd7, 8'h00, "R11 ofs7");
      wr(4'd7, 8'hFF); wr(4'd9, 8'hFF); wr(4'd15, 8'hFF);
      rd(4'd9, 8'h00, "R11 ofs9");
      rd(4'd15, 8'h00, "R11 ofs15");
      rd(4'd1, 8'h80, "R11 ctrl untouched");
      rd(4'd8, 8'h00, "R11 adp untouched");
      rd(4'd2, 8'h00, "R11 ptr untouched");

      // R2 pointer bytes
      set_ptr(24'h001234);
      rd(4'd2, 8'h34, "R2 b0");
      rd(4'd3, 8'h12, "R2 b1");
      rd(4'd4, 8'h00, "R2 b2");
      chk("R2 mem_addr", mem_addr, 24'h001234);

      // R4 increment writes
      wr(4'd6, 8'hAA); wr(4'd6, 8'hBB); wr(4'd6, 8'hCC);
      chk("R4 after inc writes", mem_addr, 24'h001237);

      // R3 hold reads, R4 increment reads
      wr(4'd2, 8'h34);
      rd(4'd5, 8'hAA, "R3 hold rd a");
      rd(4'd5, 8'hAA, "R3 hold rd b");
      chk("R3 ptr held", mem_addr, 24'h001234);
      rd(4'd6, 8'hAA, "R4 inc rd 0");
      rd(4'd6, 8'hBB, "R4 inc rd 1");
      rd(4'd6, 8'hCC, "R4 inc rd 2");
      chk("R4 ptr after inc rd", mem_addr, 24'h001237);
      wr(4'd5, 8'h55);
      chk("R3 ptr after hold wr", mem_addr, 24'h001237);
      rd(4'd5, 8'h55, "R3 hold wr data");

      // R4 wrap / R5 out of range
      set_ptr(24'hFFFFFF);
      host_addr = 4'd6; host_rd = 1'b1;
      exp_q.push_back(8'h00); tag_q.push_back("R5 rd above limit");
      #1 chk("R5 no mem_re high ptr", mem_re, 1'b0);
      @(negedge clk); host_rd = 1'b0;
      chk("R4 wrap", mem_addr, 24'h000000);

      // R5 boundary
      set_ptr(24'h03FFFF);
      host_addr = 4'd5; host_wdata = 8'h77; host_wr = 1'b1;
      #1 chk("R5 we at 3FFFF", mem_we, 1'b1);
      @(negedge clk); host_wr = 1'b0;
      set_ptr(24'h040000);
      host_addr = 4'd5; host_wdata = 8'h99; host_wr = 1'b1;
      #1 chk("R5 we at 40000", mem_we, 1'b0);
      @(negedge clk); host_wr = 1'b0;
      rd(4'd5, 8'h00, "R5 rd at 40000");
      set_ptr(24'h03FFFF);
      rd(4'd5, 8'h77, "R5 rd at 3FFFF");

      // R6 reset / halt on channel 0
      wr(4'd1, 8'h00);
      chk("R6 release ch0", adp_reset, 4'hE);
      wr(4'd1, 8'h10);
      chk("R6 halt ch0", adp_halt, 4'h1);
      rd(4'd1, 8'h10, "R6 ctrl rd");

      // R7 pending flag
      pulse_irq(0);
      rd(4'd1, 8'h50, "R7 pend set");
      wr(4'd1, 8'h10);
      rd(4'd1, 8'h50, "R7 write 0 keeps pend");
      // R9 routing code 2 -> line 5
      wr(4'd1, 8'h1A);
      chk("R9 code2 line5", host_irq, 16'h0020);
      rd(4'd8, 8'h10, "R10 summary ch0");
      wr(4'd1, 8'h5A);
      rd(4'd1, 8'h1A, "R7 w1c clears");
      chk("R9 irq drops", host_irq, 16'h0);
      // R7 set beats clear
      host_addr = 4'd1; host_wdata = 8'h5A; host_wr = 1'b1; adp_irq_set[0] = 1'b1;
      @(negedge clk); host_wr = 1'b0; adp_irq_set[0] = 1'b0;
      rd(4'd1, 8'h5A, "R7 set wins");

      // R9 code 0 and code 7
      wr(4'd1, 8'h08);
      chk("R9 code0 no line", host_irq, 16'h0);
      wr(4'd1, 8'h0F);
      chk("R9 code7 line15", host_irq, 16'h8000);
      wr(4'd1, 8'h4F);
      chk("R9 cleared", host_irq, 16'h0);

      // R8 doorbell
      wr(4'd1, 8'h2F);
      chk("R8 bell up", adp_doorbell, 4'h1);
      rd(4'd1, 8'h2F, "R8 bell reads 1");
      adp_ack[0] = 1'b1; @(negedge clk); adp_ack[0] = 1'b0;
      chk("R8 bell down", adp_doorbell, 4'h0);
      rd(4'd1, 8'h0F, "R8 bell reads 0");

      // R10 channel select
      wr(4'd8, 8'h02);
      chk("R10 mem_chan", mem_chan, 2'd2);
      wr(4'd1, 8'h90);
      chk("R10 reset vec", adp_reset, 4'hE);
      chk("R10 halt vec", adp_halt, 4'h4);
      rd(4'd1, 8'h90, "R10 ch2 ctrl");
      pulse_irq(3);
      rd(4'd8, 8'h82, "R10 summary ch3");
      wr(4'd8, 8'hF2);
      rd(4'd8, 8'h82, "R10 upper read-only");
      wr(4'd1, 8'hD0);
      rd(4'd8, 8'h82, "R10 clear wrong chan");
      wr(4'd8, 8'h03);
      wr(4'd1, 8'h40);
      rd(4'd8, 8'h03, "R10 clear ch3");
      wr(4'd8, 8'h00);
      rd(4'd1, 8'h0F, "R10 ch0 untouched");

      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
   end

   initial begin
      fork
         begin wait (done); end
         begin
            repeat (20000) @(posedge clk);
            total++; bad++;
            $display("FAIL watchdog: got=timeout exp=done");
         end
      join_any
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule